// File: doc/BRIEF.md
# Multicontext Configuration Manager

This block keeps a bank of complete configurations for a column-organised, pipelined processing array and copies a chosen one into the array's live configuration registers. One configuration is made of one slice per column. Each slice sets up one column, and each column is one pipeline stage of the array. A host-side unit writes slices into any stored context through a simple write port. It may do so while a configuration is running, so the next program can be staged in the background.

A switch command names a stored context and picks one of two swap styles. In whole-array mode every column takes its new slice on the same clock edge. In column-stepped mode column 0 is updated first, then column 1, and so on, one column per cycle. Work already in the later stages then drains under the old settings. Each column has a one-cycle update strobe. A busy flag covers the whole swap.

Top module: `cfg_ctx_manager`

## Requirements
- R1: After a synchronous reset, col_cfg is all zeros and col_upd, busy, wr_err and cmd_refused are all 0.
- R2: A context counts as loadable only once every one of its slices (slice index 0 to NUM_COLS-1) has been written since reset. A command naming a context that is not loadable is refused: cmd_refused is 1 for the cycle after the command, busy stays 0 and col_cfg is unchanged.
- R3: Whole-array mode (cmd_pipe = 0): for a command accepted on edge E0, every column takes slice k of the chosen context on edge E0+2, and col_upd is all ones for exactly that one cycle.
- R4: Column-stepped mode (cmd_pipe = 1): column k (0-based, slice k, bits k*SLICE_W upward) is loaded on edge E0+2+k, with col_upd one-hot at bit k. Columns above k keep their previous configuration until their own edge.
- R5: busy rises on the edge that accepts a command and stays high through the cycle of the last strobe. It falls on the following edge, so it lasts 3 cycles in whole-array mode and NUM_COLS+2 cycles in column-stepped mode. The first busy cycle carries no strobe.
- R6: A switch command presented while busy is ignored. It is not refused, it does not extend busy and it does not change any column.
- R7: Writes to any context other than the one being transferred are accepted while busy. They do not disturb the columns being loaded, and a later switch to that context delivers the new data.
- R8: A write that targets the context being transferred while busy is dropped, and wr_err is 1 for the following cycle. The stored slice keeps its old value.
- R9: A write whose slice index is NUM_COLS or above is dropped and raises wr_err for one cycle. It does not count toward making a context loadable.
- R10: col_upd bits are one-cycle strobes. A column's configuration changes only in a cycle where its strobe bit is set, and strobes occur only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Slice write request |
| wr_ctx | input | CTX_W (4) | Context index of the write |
| wr_col | input | COL_W (4) | Slice (column) index of the write |
| wr_data | input | SLICE_W (45) | Slice contents |
| wr_err | output | 1 | One-cycle pulse: previous write was dropped |
| cmd_valid | input | 1 | Switch command request |
| cmd_ctx | input | CTX_W (4) | Context to load |
| cmd_pipe | input | 1 | 1 = column-stepped, 0 = whole-array swap |
| cmd_refused | output | 1 | One-cycle pulse: previous command named an unloadable context |
| busy | output | 1 | Swap in progress |
| col_cfg | output | NUM_COLS*SLICE_W (405) | Live column configurations, column k at bits k*SLICE_W upward |
| col_upd | output | NUM_COLS (9) | Per-column one-cycle update strobes |

## Verification
The bench fills every context with data that is a function of context, column and a salt. It then swaps to each context in both modes and checks every column on every cycle of each swap. A design that loaded columns in the wrong order, or one cycle early or late, would show a column with the wrong value or a strobe in the wrong place. During column-stepped swaps the bench injects three things: a command, which must be ignored, a write to a different context, which must land, and a write to the context being loaded, which must be rejected. A design that accepted the command would restart or lengthen busy, and one that let the conflicting write through would show the wrong slice on a later reload. The bench also tries partially written contexts and out-of-range slice indices. A design that validated a context too early, or aliased the index, would accept a command the bench expects to be refused.

// File: rtl/cfgmgr_pkg.sv
package cfgmgr_pkg;
  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_FETCH = 2'd1,
    SW_APPLY = 2'd2,
    SW_DRAIN = 2'd3
  } sw_state_t;
endpackage

// File: rtl/ctx_bank.sv
// One column's slice store across all contexts; simple dual port, registered read.
module ctx_bank #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 45,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctx_valid_map.sv
// Tracks which slices of each context have been written since reset.
module ctx_valid_map #(
  parameter int NUM_CTX  = 16,
  parameter int NUM_COLS = 9,
  parameter int CTX_W    = $clog2(NUM_CTX),
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mark,
  input  logic [CTX_W-1:0] mark_ctx,
  input  logic [COL_W-1:0] mark_col,
  input  logic [CTX_W-1:0] query_ctx,
  output logic             query_full
);
  logic [NUM_COLS-1:0] seen [NUM_CTX];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CTX; i++) seen[i] <= '0;
    end else if (mark) begin
      seen[mark_ctx][mark_col] <= 1'b1;
    end
  end

  assign query_full = &seen[query_ctx];
endmodule

// File: rtl/swap_ctrl.sv
// Command acceptance and column loading sequence.
module swap_ctrl
  import cfgmgr_pkg::*;
#(
  parameter int NUM_COLS = 9,
  parameter int SLICE_W  = 45,
  parameter int CTX_W    = 4,
  parameter int STEP_W   = $clog2(NUM_COLS),
  parameter int CFG_W    = NUM_COLS * SLICE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [CTX_W-1:0]   cmd_ctx,
  input  logic               cmd_pipe,
  input  logic               ctx_ready,
  input  logic [CFG_W-1:0]   rd_data,
  output logic [CTX_W-1:0]   cur_ctx,
  output logic               busy,
  output logic               cmd_refused,
  output logic [CFG_W-1:0]   col_cfg,
  output logic [NUM_COLS-1:0] col_upd
);
  sw_state_t          state;
  logic               pipe_q;
  logic [STEP_W-1:0]  step;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SW_IDLE;
      cur_ctx     <= '0;
      pipe_q      <= 1'b0;
      step        <= '0;
      busy        <= 1'b0;
      cmd_refused <= 1'b0;
      col_cfg     <= '0;
      col_upd     <= '0;
    end else begin
      cmd_refused <= 1'b0;
      col_upd     <= '0;
      case (state)
        SW_IDLE: begin
          if (cmd_valid) begin
            if (ctx_ready) begin
              state   <= SW_FETCH;
              cur_ctx <= cmd_ctx;
              pipe_q  <= cmd_pipe;
              busy    <= 1'b1;
            end else begin
              cmd_refused <= 1'b1;
            end
          end
        end
        SW_FETCH: begin
          state <= SW_APPLY;
          step  <= '0;
        end
        SW_APPLY: begin
          if (!pipe_q) begin
            col_cfg <= rd_data;
            col_upd <= '1;
            state   <= SW_DRAIN;
          end else begin
            for (int k = 0; k < NUM_COLS; k++) begin
              if (step == STEP_W'(k)) begin
                col_cfg[k*SLICE_W +: SLICE_W] <= rd_data[k*SLICE_W +: SLICE_W];
                col_upd[k] <= 1'b1;
              end
            end
            if (step == STEP_W'(NUM_COLS - 1)) state <= SW_DRAIN;
            else                               step  <= step + 1'b1;
          end
        end
        SW_DRAIN: begin
          busy  <= 1'b0;
          state <= SW_IDLE;
        end
        default: state <= SW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_ctx_manager.sv
module cfg_ctx_manager #(
  parameter int NUM_CTX  = 16,
  parameter int NUM_COLS = 9,
  parameter int SLICE_W  = 45,
  parameter int CTX_W    = $clog2(NUM_CTX),
  parameter int COL_W    = $clog2(NUM_COLS),
  parameter int CFG_W    = NUM_COLS * SLICE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CTX_W-1:0]    wr_ctx,
  input  logic [COL_W-1:0]    wr_col,
  input  logic [SLICE_W-1:0]  wr_data,
  output logic                wr_err,
  input  logic                cmd_valid,
  input  logic [CTX_W-1:0]    cmd_ctx,
  input  logic                cmd_pipe,
  output logic                cmd_refused,
  output logic                busy,
  output logic [CFG_W-1:0]    col_cfg,
  output logic [NUM_COLS-1:0] col_upd
);
  logic [CTX_W-1:0] cur_ctx;
  logic             col_in_range;
  logic             ctx_clash;
  logic             wr_ok;
  logic             ctx_ready;
  logic [CFG_W-1:0] rd_data;

  assign col_in_range = ({1'b0, wr_col} < (COL_W + 1)'(NUM_COLS));
  assign ctx_clash    = busy && (wr_ctx == cur_ctx);
  assign wr_ok        = wr_en && col_in_range && !ctx_clash;

  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= wr_en && !wr_ok;
  end

  for (genvar k = 0; k < NUM_COLS; k++) begin : g_bank
    ctx_bank #(
      .DEPTH (NUM_CTX),
      .WIDTH (SLICE_W),
      .AW    (CTX_W)
    ) u_bank (
      .clk   (clk),
      .we    (wr_ok && (wr_col == COL_W'(k))),
      .waddr (wr_ctx),
      .wdata (wr_data),
      .raddr (cur_ctx),
      .rdata (rd_data[k*SLICE_W +: SLICE_W])
    );
  end

  ctx_valid_map #(
    .NUM_CTX  (NUM_CTX),
    .NUM_COLS (NUM_COLS),
    .CTX_W    (CTX_W),
    .COL_W    (COL_W)
  ) u_valid (
    .clk        (clk),
    .rst        (rst),
    .mark       (wr_ok),
    .mark_ctx   (wr_ctx),
    .mark_col   (wr_col),
    .query_ctx  (cmd_ctx),
    .query_full (ctx_ready)
  );

  swap_ctrl #(
    .NUM_COLS (NUM_COLS),
    .SLICE_W  (SLICE_W),
    .CTX_W    (CTX_W),
    .STEP_W   (COL_W),
    .CFG_W    (CFG_W)
  ) u_swap (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_ctx     (cmd_ctx),
    .cmd_pipe    (cmd_pipe),
    .ctx_ready   (ctx_ready),
    .rd_data     (rd_data),
    .cur_ctx     (cur_ctx),
    .busy        (busy),
    .cmd_refused (cmd_refused),
    .col_cfg     (col_cfg),
    .col_upd     (col_upd)
  );
endmodule

// File: rtl/cfg_ctx_manager_chk.sv
module cfg_ctx_manager_chk #(
  parameter int NUM_COLS = 9,
  parameter int SLICE_W  = 45
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic                         wr_err,
  input logic                         cmd_valid,
  input logic                         cmd_refused,
  input logic                         busy,
  input logic [NUM_COLS*SLICE_W-1:0]  col_cfg,
  input logic [NUM_COLS-1:0]          col_upd
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_UPD_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (col_upd != '0) |-> busy); // R10

  AST_UPD_SHAPE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_upd) || (&col_upd)); // R4

  AST_BUSY_START_QUIET: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(busy) |-> (col_upd == '0)); // R5

  AST_BUSY_END_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(busy) |-> ($past(col_upd) != '0)); // R5

  AST_REFUSE_IDLE: assert property (@(posedge clk) disable iff (rst || !armed)
    cmd_refused |-> (!busy && $past(cmd_valid))); // R2

  AST_WRERR_CAUSE: assert property (@(posedge clk) disable iff (rst || !armed)
    wr_err |-> $past(wr_en)); // R9

  for (genvar k = 0; k < NUM_COLS; k++) begin : g_col
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
      !col_upd[k] |-> $stable(col_cfg[k*SLICE_W +: SLICE_W])); // R10
  end
endmodule

bind cfg_ctx_manager cfg_ctx_manager_chk #(
  .NUM_COLS (NUM_COLS),
  .SLICE_W  (SLICE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_err      (wr_err),
  .cmd_valid   (cmd_valid),
  .cmd_refused (cmd_refused),
  .busy        (busy),
  .col_cfg     (col_cfg),
  .col_upd     (col_upd)
);

// File: tb/tb_cfg_ctx_manager.sv
`timescale 1ns/1ps
module tb_cfg_ctx_manager;
  localparam int NC = 16;
  localparam int NK = 9;
  localparam int SW = 45;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [3:0]     wr_ctx = '0;
  logic [3:0]     wr_col = '0;
  logic [SW-1:0]  wr_data = '0;
  logic           wr_err;
  logic           cmd_valid = 1'b0;
  logic [3:0]     cmd_ctx = '0;
  logic           cmd_pipe = 1'b0;
  logic           cmd_refused;
  logic           busy;
  logic [NK*SW-1:0] col_cfg;
  logic [NK-1:0]  col_upd;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [SW-1:0] exp_mem [NC][NK];
  logic [SW-1:0] cur [NK];

  always #2.5 clk = ~clk;

  cfg_ctx_manager dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_col(wr_col),
    .wr_data(wr_data), .wr_err(wr_err), .cmd_valid(cmd_valid), .cmd_ctx(cmd_ctx),
    .cmd_pipe(cmd_pipe), .cmd_refused(cmd_refused), .busy(busy),
    .col_cfg(col_cfg), .col_upd(col_upd)
  );

  function automatic logic [SW-1:0] pat(int c, int k, int salt);
    logic [28:0] tail;
    tail = 29'(c * 104729 + k * 7919 + salt * 613 + 17);
    return {8'(salt), 4'(c), 4'(k), tail};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int c, int k, logic [SW-1:0] d);
    wr_en = 1'b1; wr_ctx = 4'(c); wr_col = 4'(k); wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic check_cols(string req, int c, int upto, bit use_new);
    for (int j = 0; j < NK; j++) begin
      logic [SW-1:0] e;
      e = (use_new && j <= upto) ? exp_mem[c][j] : cur[j];
      chk(col_cfg[j*SW +: SW] == e, req, $sformatf("column %0d", j),
          64'(col_cfg[j*SW +: SW]), 64'(e));
    end
  endtask

  task automatic refuse_cmd(int c, string req);
    cmd_valid = 1'b1; cmd_ctx = 4'(c); cmd_pipe = 1'b0;
    step();
    cmd_valid = 1'b0;
    chk(cmd_refused == 1'b1, req, "cmd_refused", 64'(cmd_refused), 64'd1);
    chk(busy == 1'b0, req, "busy after refusal", 64'(busy), 64'd0);
    step();
    chk(cmd_refused == 1'b0, req, "refused pulse width", 64'(cmd_refused), 64'd0);
    chk(col_upd == '0, req, "no strobe after refusal", 64'(col_upd), 64'd0);
  endtask

  task automatic load(int c, bit pipe, bit inject);
    cmd_valid = 1'b1; cmd_ctx = 4'(c); cmd_pipe = pipe;
    step();
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R5", "busy after accept", 64'(busy), 64'd1);
    chk(col_upd == '0, "R5", "first busy cycle strobe", 64'(col_upd), 64'd0);
    step();
    chk(col_upd == '0, "R3", "fetch cycle strobe", 64'(col_upd), 64'd0);
    if (!pipe) begin
      step();
      chk(col_upd == '1, "R3", "all-column strobe", 64'(col_upd), 64'h1ff);
      chk(busy == 1'b1, "R5", "busy on strobe", 64'(busy), 64'd1);
      check_cols("R3", c, NK - 1, 1'b1);
      for (int j = 0; j < NK; j++) cur[j] = exp_mem[c][j];
      step();
      chk(busy == 1'b0, "R5", "busy end parallel", 64'(busy), 64'd0);
      chk(col_upd == '0, "R10", "strobe width", 64'(col_upd), 64'd0);
    end else begin
      for (int k = 0; k < NK; k++) begin
        if (inject && k == 3) begin
          wr_en = 1'b1; wr_ctx = 4'((c + 1) % NC); wr_col = 4'(k);
          wr_data = pat((c + 1) % NC, k, 1);
          exp_mem[(c + 1) % NC][k] = wr_data;
        end
        if (inject && k == 4) begin
          cmd_valid = 1'b1; cmd_ctx = 4'((c + 2) % NC); cmd_pipe = 1'b0;
        end
        if (inject && k == 5) begin
          wr_en = 1'b1; wr_ctx = 4'(c); wr_col = 4'd0; wr_data = pat(c, 0, 2);
        end
        step();
        wr_en = 1'b0; cmd_valid = 1'b0;
        chk(col_upd == NK'(1 << k), "R4", $sformatf("strobe step %0d", k),
            64'(col_upd), 64'(1 << k));
        chk(busy == 1'b1, "R5", "busy during steps", 64'(busy), 64'd1);
        check_cols("R4", c, k, 1'b1);
        if (inject && k == 3)
          chk(wr_err == 1'b0, "R7", "background write accepted", 64'(wr_err), 64'd0);
        if (inject && k == 5)
          chk(wr_err == 1'b1, "R8", "clash write rejected", 64'(wr_err), 64'd1);
      end
      for (int j = 0; j < NK; j++) cur[j] = exp_mem[c][j];
      step();
      chk(busy == 1'b0, "R5", "busy end stepped", 64'(busy), 64'd0);
      chk(col_upd == '0, "R10", "strobe after last", 64'(col_upd), 64'd0);
      if (inject) begin
        step();
        chk(busy == 1'b0, "R6", "ignored command stays idle", 64'(busy), 64'd0);
        chk(cmd_refused == 1'b0, "R6", "ignored command not refused", 64'(cmd_refused), 64'd0);
        check_cols("R6", c, NK - 1, 1'b1);
      end
    end
  endtask

  initial begin
    for (int j = 0; j < NK; j++) cur[j] = '0;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1
    chk(col_cfg == '0, "R1", "col_cfg reset", 64'(col_cfg[63:0]), 64'd0);
    chk(col_upd == '0, "R1", "col_upd reset", 64'(col_upd), 64'd0);
    chk(busy == 1'b0, "R1", "busy reset", 64'(busy), 64'd0);
    chk(wr_err == 1'b0, "R1", "wr_err reset", 64'(wr_err), 64'd0);
    chk(cmd_refused == 1'b0, "R1", "cmd_refused reset", 64'(cmd_refused), 64'd0);

    // R2: never written, then partially written
    refuse_cmd(0, "R2");
    for (int k = 0; k < NK - 1; k++) begin
      wr(0, k, pat(0, k, 0));
      chk(wr_err == 1'b0, "R2", "in-range write", 64'(wr_err), 64'd0);
    end
    refuse_cmd(0, "R2");
    check_cols("R2", 0, 0, 1'b0);

    // R9: out-of-range slice index
    for (int k = 0; k < NK - 1; k++) wr(2, k, pat(2, k, 0));
    for (int k = NK; k < 16; k++) begin
      wr(2, k, pat(2, 0, 3));
      chk(wr_err == 1'b1, "R9", $sformatf("index %0d", k), 64'(wr_err), 64'd1);
    end
    step();
    chk(wr_err == 1'b0, "R9", "wr_err pulse width", 64'(wr_err), 64'd0);
    refuse_cmd(2, "R9");

    // Fill every context
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < NK; k++) begin
        exp_mem[c][k] = pat(c, k, 0);
        wr(c, k, exp_mem[c][k]);
      end

    for (int c = 0; c < NC; c++) load(c, 1'b0, 1'b0);          // R3
    for (int c = 0; c < NC; c++) load(c, 1'b1, (c % 4) == 0);  // R4 R6 R7 R8
    for (int c = 0; c < NC; c++) load(c, 1'b0, 1'b0);          // R7 R8 data survive

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule